// File: doc/BRIEF.md
# Execute-Operand and Decode-Read Bypass Selector

This block settles where each operand of an in-order pipeline should take its value from. For each execute-stage ALU operand it compares the operand's source register index with the destinations of the two younger results still in flight. The first is the result held after execute, one stage ahead. The second is the value about to be written back, two stages ahead. It then produces a 2-bit select and the muxed operand word. The younger result wins when both match. Register index zero is hard-wired to zero in the register file, so it is never taken from a bypass.

For each decode-stage register-file read port, the block raises a flag and swaps in the writeback value when that port reads the register being written in the same cycle. This lets decode see the new value without splitting the clock into write and read halves. Every path is combinational, so a forwarded value reaches the ALU input or the decode read result in the same cycle as the compare. The number of operands, the number of read ports, the register index width and the data width are parameters. Stalling for load-use cases is handled elsewhere.

Top module: `operand_forward_unit`

## Requirements
- R1: When the post-execute result is being written (`xr_wen`=1), its destination `xr_dst` is nonzero and `xr_dst` equals an operand's source index, that operand's select is 2'b10 and its output word is `xr_data`.
- R2: When the writeback value is being written (`wb_wen`=1) to a nonzero `wb_dst` equal to an operand's source index, and R1 does not hold for that operand, its select is 2'b01 and its output word is `wb_data`.
- R3: When both R1 and R2 conditions hold for one operand, the select is 2'b10 and the word is `xr_data`; the younger result wins.
- R4: An operand whose source index is 0 always has select 2'b00 and takes its register-file word, even if a result with destination 0 is being written.
- R5: When neither condition holds, including when the matching producer has its write enable low, the select is 2'b00 and the output word is the operand's own register-file word.
- R6: Each operand is resolved independently. Operand k uses slice k of `ex_src`, `ex_rf` and `ex_sel`, and its result depends on no other operand's index.
- R7: A decode read port whose address equals a nonzero `wb_dst` while `wb_wen`=1 has its bypass flag set to 1 and outputs `wb_data`. Otherwise the flag is 0 and the port outputs its register-file word.
- R8: A decode read of address 0 never bypasses, and the post-execute result never feeds a decode read port.
- R9: All outputs follow their inputs within the same cycle, through combinational paths and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src | input | N_EX*AW | Source register index per execute operand |
| ex_rf | input | N_EX*DW | Register-file word per execute operand |
| xr_wen | input | 1 | Post-execute result will write a register |
| xr_dst | input | AW | Post-execute destination index |
| xr_data | input | DW | Post-execute result word |
| wb_wen | input | 1 | Writeback stage is writing a register |
| wb_dst | input | AW | Writeback destination index |
| wb_data | input | DW | Writeback value |
| rd_addr | input | N_RD*AW | Decode read address per port |
| rd_rf | input | N_RD*DW | Register-file read word per port |
| ex_sel | output | N_EX*2 | Operand source select: 00 file, 01 writeback, 10 post-execute |
| ex_opnd | output | N_EX*DW | Resolved execute operand words |
| rd_byp | output | N_RD | Decode port took the writeback value |
| rd_word | output | N_RD*DW | Resolved decode read words |

## Verification
The block holds no state, so a wrong decision in its compare or priority logic appears at the select and data ports in the same cycle as the inputs that expose it. No later cycle can hide it or bring it out. A select that is swapped or wrongly encoded shows as a select with the wrong bit pattern. It also shows as an operand word carrying the wrong one of three distinct data patterns. A broken register-zero guard or priority order shows only for particular index combinations. For this reason every index, enable and destination combination of a 2-bit index configuration is swept, and each one is checked on both operands and both read ports.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE   = 2'b00,
        SRC_WRITEBACK = 2'b01,
        SRC_EXECUTED  = 2'b10
    } opnd_src_e;

endpackage

// File: rtl/dest_match.sv
module dest_match #(
    parameter int AW = 5
) (
    input  logic          wen,
    input  logic [AW-1:0] dst,
    input  logic [AW-1:0] idx,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_IDX = '0;

    always_comb begin
        hit = wen && (dst != ZERO_IDX) && (dst == idx);
    end

endmodule

// File: rtl/ex_operand_path.sv
module ex_operand_path
    import opfwd_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic [AW-1:0] src_idx,
    input  logic [DW-1:0] rf_word,
    input  logic          xr_wen,
    input  logic [AW-1:0] xr_dst,
    input  logic [DW-1:0] xr_data,
    input  logic          wb_wen,
    input  logic [AW-1:0] wb_dst,
    input  logic [DW-1:0] wb_data,
    output logic [1:0]    sel,
    output logic [DW-1:0] opnd
);
    logic      hit_xr;
    logic      hit_wb;
    opnd_src_e pick;

    dest_match #(.AW(AW)) u_xr_cmp (.wen(xr_wen), .dst(xr_dst), .idx(src_idx), .hit(hit_xr));
    dest_match #(.AW(AW)) u_wb_cmp (.wen(wb_wen), .dst(wb_dst), .idx(src_idx), .hit(hit_wb));

    // Younger result first (R3), then writeback (R2), else the file (R5).
    always_comb begin
        if (hit_xr)      pick = SRC_EXECUTED;
        else if (hit_wb) pick = SRC_WRITEBACK;
        else             pick = SRC_REGFILE;
    end

    always_comb begin
        sel = pick;
        unique case (pick)
            SRC_EXECUTED:  opnd = xr_data;
            SRC_WRITEBACK: opnd = wb_data;
            default:       opnd = rf_word;
        endcase
    end

    always_comb begin
        if (!$isunknown({src_idx, xr_wen, xr_dst, wb_wen, wb_dst, xr_data, wb_data, rf_word})) begin
            a_r3_sel_legal:    assert ($onehot0(sel));
            a_r4_zero_from_rf: assert ((src_idx != '0) || (sel == 2'b00));
            a_r1_xr_word:      assert ((sel != 2'b10) || (opnd == xr_data));
            a_r2_wb_word:      assert ((sel != 2'b01) || (opnd == wb_data));
        end
    end

endmodule

// File: rtl/dec_read_bypass.sv
module dec_read_bypass #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rf_word,
    input  logic          wb_wen,
    input  logic [AW-1:0] wb_dst,
    input  logic [DW-1:0] wb_data,
    output logic          byp,
    output logic [DW-1:0] word
);
    logic hit;

    dest_match #(.AW(AW)) u_cmp (.wen(wb_wen), .dst(wb_dst), .idx(addr), .hit(hit));

    always_comb begin
        byp  = hit;
        word = hit ? wb_data : rf_word;
    end

    always_comb begin
        if (!$isunknown({addr, wb_wen, wb_dst, wb_data, rf_word})) begin
            a_r8_zero_no_bypass: assert ((addr != '0) || !byp);
            a_r7_bypass_word:    assert (!byp || (word == wb_data));
            a_r7_file_word:      assert (byp || (word == rf_word));
        end
    end

endmodule

// File: rtl/operand_forward_unit.sv
module operand_forward_unit #(
    parameter int AW   = 5,
    parameter int DW   = 32,
    parameter int N_EX = 2,
    parameter int N_RD = 2
) (
    input  logic [N_EX*AW-1:0] ex_src,
    input  logic [N_EX*DW-1:0] ex_rf,
    input  logic               xr_wen,
    input  logic [AW-1:0]      xr_dst,
    input  logic [DW-1:0]      xr_data,
    input  logic               wb_wen,
    input  logic [AW-1:0]      wb_dst,
    input  logic [DW-1:0]      wb_data,
    input  logic [N_RD*AW-1:0] rd_addr,
    input  logic [N_RD*DW-1:0] rd_rf,
    output logic [N_EX*2-1:0]  ex_sel,
    output logic [N_EX*DW-1:0] ex_opnd,
    output logic [N_RD-1:0]    rd_byp,
    output logic [N_RD*DW-1:0] rd_word
);
    localparam int SW = 2;

    // R6: one identical, independent path per execute operand.
    for (genvar k = 0; k < N_EX; k++) begin : g_ex
        ex_operand_path #(.AW(AW), .DW(DW)) u_path (
            .src_idx (ex_src[k*AW +: AW]),
            .rf_word (ex_rf[k*DW +: DW]),
            .xr_wen  (xr_wen),
            .xr_dst  (xr_dst),
            .xr_data (xr_data),
            .wb_wen  (wb_wen),
            .wb_dst  (wb_dst),
            .wb_data (wb_data),
            .sel     (ex_sel[k*SW +: SW]),
            .opnd    (ex_opnd[k*DW +: DW])
        );
    end

    // R7/R8: decode ports see only the writeback value.
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        dec_read_bypass #(.AW(AW), .DW(DW)) u_byp (
            .addr    (rd_addr[p*AW +: AW]),
            .rf_word (rd_rf[p*DW +: DW]),
            .wb_wen  (wb_wen),
            .wb_dst  (wb_dst),
            .wb_data (wb_data),
            .byp     (rd_byp[p]),
            .word    (rd_word[p*DW +: DW])
        );
    end

endmodule

// File: tb/sim_operand_forward_unit.sv
module sim_operand_forward_unit;
    localparam int AW = 2;
    localparam int DW = 8;
    localparam int NR = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2*AW-1:0] ex_src = '0;
    logic [2*DW-1:0] ex_rf  = '0;
    logic            xr_wen = 1'b0;
    logic [AW-1:0]   xr_dst = '0;
    logic [DW-1:0]   xr_data = '0;
    logic            wb_wen = 1'b0;
    logic [AW-1:0]   wb_dst = '0;
    logic [DW-1:0]   wb_data = '0;
    logic [2*AW-1:0] rd_addr = '0;
    logic [2*DW-1:0] rd_rf = '0;
    logic [3:0]      ex_sel;
    logic [2*DW-1:0] ex_opnd;
    logic [1:0]      rd_byp;
    logic [2*DW-1:0] rd_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    operand_forward_unit #(.AW(AW), .DW(DW), .N_EX(2), .N_RD(2)) u0 (
        .ex_src(ex_src), .ex_rf(ex_rf), .xr_wen(xr_wen), .xr_dst(xr_dst),
        .xr_data(xr_data), .wb_wen(wb_wen), .wb_dst(wb_dst), .wb_data(wb_data),
        .rd_addr(rd_addr), .rd_rf(rd_rf), .ex_sel(ex_sel), .ex_opnd(ex_opnd),
        .rd_byp(rd_byp), .rd_word(rd_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // Idle: everything from the file (R5, R9).
        chk("R5 idle sel", {28'd0, ex_sel}, 32'd0);
        chk("R7 idle byp", {30'd0, rd_byp}, 32'd0);
        ex_rf   = {8'h22, 8'h11};
        rd_rf   = {8'h44, 8'h33};
        xr_data = 8'hA5;
        wb_data = 8'h5C;
        for (int sa = 0; sa < NR; sa++)
        for (int sb = 0; sb < NR; sb++)
        for (int xw = 0; xw < 2; xw++)
        for (int xd = 0; xd < NR; xd++)
        for (int ww = 0; ww < 2; ww++)
        for (int wd = 0; wd < NR; wd++) begin
            @(posedge clk); #1;
            ex_src  = {sb[AW-1:0], sa[AW-1:0]};
            rd_addr = {sb[AW-1:0], sa[AW-1:0]};
            xr_wen  = xw[0];
            xr_dst  = xd[AW-1:0];
            wb_wen  = ww[0];
            wb_dst  = wd[AW-1:0];
            #1;
            for (int k = 0; k < 2; k++) begin
                int s;
                bit hx, hw;
                logic [1:0] es;
                logic [DW-1:0] ew;
                s  = (k == 0) ? sa : sb;
                hx = (xw == 1) && (xd != 0) && (xd == s);
                hw = (ww == 1) && (wd != 0) && (wd == s);
                if (hx)      begin es = 2'b10; ew = 8'hA5; end
                else if (hw) begin es = 2'b01; ew = 8'h5C; end
                else         begin es = 2'b00; ew = (k == 0) ? 8'h11 : 8'h22; end
                if (hx && hw)      begin chk("R3 sel", {30'd0, ex_sel[k*2 +: 2]}, {30'd0, es}); chk("R3 word", {24'd0, ex_opnd[k*DW +: DW]}, {24'd0, ew}); end
                else if (hx)       begin chk("R1 sel", {30'd0, ex_sel[k*2 +: 2]}, {30'd0, es}); chk("R1 word", {24'd0, ex_opnd[k*DW +: DW]}, {24'd0, ew}); end
                else if (hw)       begin chk("R2 sel", {30'd0, ex_sel[k*2 +: 2]}, {30'd0, es}); chk("R2 word", {24'd0, ex_opnd[k*DW +: DW]}, {24'd0, ew}); end
                else if (s == 0)   begin chk("R4 sel", {30'd0, ex_sel[k*2 +: 2]}, {30'd0, es}); chk("R4 word", {24'd0, ex_opnd[k*DW +: DW]}, {24'd0, ew}); end
                else               begin chk("R5 R6 sel", {30'd0, ex_sel[k*2 +: 2]}, {30'd0, es}); chk("R5 R6 word", {24'd0, ex_opnd[k*DW +: DW]}, {24'd0, ew}); end
                // Decode port k reads the same index.
                hw = (ww == 1) && (wd != 0) && (wd == s);
                ew = hw ? 8'h5C : ((k == 0) ? 8'h33 : 8'h44);
                if (s == 0) chk("R8 byp", {31'd0, rd_byp[k]}, 32'd0);
                else        chk("R7 byp", {31'd0, rd_byp[k]}, {31'd0, hw});
                chk("R7 R8 R9 word", {24'd0, rd_word[k*DW +: DW]}, {24'd0, ew});
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule